// File: doc/BRIEF.md
# Compare-Match Interval Timer

The block is a memory-mapped timer peripheral built around a free-running up-counter. Each count step is produced by picking one of three count-enable strobes (bus clock, peripheral clock or an oscillator path), optionally thinning the oscillator strobe with its own divider, and then passing the result through a main divider. All strobes are single-cycle enables in the block's own clock domain, so the block needs no clock multiplexing.

One compare channel watches the counter. When a count step brings the counter to the compare value, a sticky status flag sets. Software clears it by writing one to it. An interrupt-enable bit gates the flag onto a registered interrupt line. A mode bit chooses between two behaviours: the counter keeps running through the match, or it restarts from zero after it.

Software reaches every register through a plain 32-bit write port with a combinational read-data path. The counter is read-only.

Top module: `cmp_timer`

## Requirements
- R1: After reset, the control, divider, status and interrupt-enable registers read 0, the counter reads 0, the compare register reads all ones (CNT_W bits, zero-extended) and `irq_o` is low.
- R2: Control bit 0 enables the block. While it is 0, both divider counts are cleared and the counter is held at 0.
- R3: Control bits [8:6] select the count strobe. Code 1 selects `bus_tick_i`, code 2 selects `per_tick_i` and code 5 selects the oscillator path. Any other code produces no count steps.
- R4: Divider register bits [11:0] hold a value N. The counter steps once for every N+1 selected strobes.
- R5: When control bit 10 is 1, the oscillator path divides `osc_tick_i` by M+1, where M is divider register bits [15:12]. When bit 10 is 0, the oscillator strobe passes through undivided. This divider is used only by source code 5.
- R6: With control bit 9 set (free-run), the counter increments on every count step, passes through a compare match without interruption and wraps from all ones to 0.
- R7: With control bit 9 clear (restart), a count step taken while the counter equals the compare value loads 0. This gives a period of compare+1 steps; with a compare value of 0, every step is a match.
- R8: Status bit 0 (offset 0x08) sets on a count step whose new counter value equals the compare value. It remains set until a write to offset 0x08 with data bit 0 = 1. A write with bit 0 = 0 leaves it unchanged. A match in the same cycle as a clearing write wins.
- R9: `irq_o` is high exactly one cycle after status bit 0 and interrupt-enable bit 0 (offset 0x0C) are both 1. Writing 0 to offset 0x0C masks the interrupt and leaves status bit 0 unchanged.
- R10: A write to the compare register (offset 0x10) is used by the match and restart logic from the next clock edge onward.
- R11: Reads decode control 0x00, divider 0x04, status 0x08, interrupt enable 0x0C, compare 0x10 and counter 0x24. Writes to 0x24 are ignored, and reads of any other offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_tick_i | input | 1 | Bus-clock count strobe |
| per_tick_i | input | 1 | Peripheral-clock count strobe |
| osc_tick_i | input | 1 | Oscillator count strobe |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Registered compare interrupt |

## Verification
The bench builds the block with CNT_W = 8 and keeps the default divider widths. With an 8-bit counter, the free-run wrap from 0xFF to 0 and the all-ones compare value left by reset both occur within a few hundred cycles, so the bench observes them directly rather than leaving them untested. The full 12-bit and 4-bit divider fields stay in place, so the bench exercises the oscillator divider and the main divider together at their real bit positions.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] OFF_CTRL = 6'h00;
    localparam logic [ADDR_W-1:0] OFF_DIV  = 6'h04;
    localparam logic [ADDR_W-1:0] OFF_STAT = 6'h08;
    localparam logic [ADDR_W-1:0] OFF_IEN  = 6'h0C;
    localparam logic [ADDR_W-1:0] OFF_CMP  = 6'h10;
    localparam logic [ADDR_W-1:0] OFF_CNT  = 6'h24;

    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_BUS  = 3'd1,
        SRC_PER  = 3'd2,
        SRC_OSC  = 3'd5
    } tick_src_e;

    localparam int BIT_EN   = 0;
    localparam int BIT_SRC  = 6;
    localparam int BIT_FREE = 9;
    localparam int BIT_OSCD = 10;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int W = 12
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clr_i,
    input  logic         strobe_i,
    input  logic [W-1:0] ratio_m1_i,
    output logic         fire_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        fire_o = 1'b0;
        if (clr_i) begin
            cnt_d = '0;
        end else if (strobe_i) begin
            if (cnt_q >= ratio_m1_i) begin
                fire_o = 1'b1;
                cnt_d  = '0;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    // R4
    fire_needs_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fire_o |-> (strobe_i && !clr_i));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         en_i,
    input  logic         step_i,
    input  logic         freerun_i,
    input  logic [W-1:0] cmp_i,
    output logic [W-1:0] cnt_o,
    output logic         match_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d   = cnt_q;
        match_o = 1'b0;
        if (!en_i) begin
            cnt_d = '0;
        end else if (step_i) begin
            if (!freerun_i && (cnt_q == cmp_i)) cnt_d = '0;
            else                                cnt_d = cnt_q + 1'b1;
            match_o = (cnt_d == cmp_i);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    // R2
    hold_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (cnt_q == '0));
    // R6
    freerun_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && step_i && freerun_i) |=> (cnt_q == $past(cnt_q) + 1'b1));
    // R7
    restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && step_i && !freerun_i && cnt_q == cmp_i) |=> (cnt_q == '0));
    // R2
    no_step_no_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && !step_i) |=> $stable(cnt_q));
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
    import tmr_pkg::*;
#(
    parameter int ADDR_W     = tmr_pkg::ADDR_W,
    parameter int CNT_W      = 32,
    parameter int MAIN_PRE_W = 12,
    parameter int OSC_PRE_W  = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_tick_i,
    input  logic              per_tick_i,
    input  logic              osc_tick_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    output logic [31:0]       rdata_o,
    output logic              irq_o
);
    localparam int OSC_LSB = MAIN_PRE_W;

    typedef struct packed {
        logic [31:0]      ctrl;
        logic [31:0]      div;
        logic             flag;
        logic             ien;
        logic [CNT_W-1:0] cmp;
        logic             irq;
    } regs_t;

    regs_t r_d, r_q;

    logic             en, osc_div_on, freerun;
    logic [2:0]       src;
    logic             osc_fire, osc_path, sel_strobe, step, match, clr_wr;
    logic [CNT_W-1:0] cnt;

    assign en         = r_q.ctrl[BIT_EN];
    assign src        = r_q.ctrl[BIT_SRC +: 3];
    assign freerun    = r_q.ctrl[BIT_FREE];
    assign osc_div_on = r_q.ctrl[BIT_OSCD];

    tmr_prescale #(.W(OSC_PRE_W)) u_osc_div (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .clr_i      (!(en && osc_div_on)),
        .strobe_i   (osc_tick_i),
        .ratio_m1_i (r_q.div[OSC_LSB +: OSC_PRE_W]),
        .fire_o     (osc_fire)
    );

    assign osc_path = osc_div_on ? osc_fire : osc_tick_i;

    always_comb begin
        unique case (src)
            SRC_BUS: sel_strobe = bus_tick_i;
            SRC_PER: sel_strobe = per_tick_i;
            SRC_OSC: sel_strobe = osc_path;
            default: sel_strobe = 1'b0;
        endcase
    end

    tmr_prescale #(.W(MAIN_PRE_W)) u_main_div (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .clr_i      (!en),
        .strobe_i   (sel_strobe),
        .ratio_m1_i (r_q.div[MAIN_PRE_W-1:0]),
        .fire_o     (step)
    );

    tmr_counter #(.W(CNT_W)) u_cnt (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .en_i      (en),
        .step_i    (step),
        .freerun_i (freerun),
        .cmp_i     (r_q.cmp),
        .cnt_o     (cnt),
        .match_o   (match)
    );

    assign clr_wr = wr_en_i && (addr_i == OFF_STAT) && wdata_i[0];

    always_comb begin
        r_d     = r_q;
        r_d.irq = r_q.flag && r_q.ien;
        if (clr_wr) r_d.flag = 1'b0;
        if (match)  r_d.flag = 1'b1;
        if (wr_en_i) begin
            unique case (addr_i)
                OFF_CTRL: r_d.ctrl = wdata_i;
                OFF_DIV:  r_d.div  = wdata_i;
                OFF_IEN:  r_d.ien  = wdata_i[0];
                OFF_CMP:  r_d.cmp  = wdata_i[CNT_W-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q     <= '0;
            r_q.cmp <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        unique case (addr_i)
            OFF_CTRL: rdata_o = r_q.ctrl;
            OFF_DIV:  rdata_o = r_q.div;
            OFF_STAT: rdata_o = {31'd0, r_q.flag};
            OFF_IEN:  rdata_o = {31'd0, r_q.ien};
            OFF_CMP:  rdata_o = 32'(r_q.cmp);
            OFF_CNT:  rdata_o = 32'(cnt);
            default:  rdata_o = 32'd0;
        endcase
    end

    assign irq_o = r_q.irq;

    // R8
    flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.flag && !clr_wr) |=> r_q.flag);
    // R8
    flag_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        match |=> r_q.flag);
    // R9
    irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.flag && r_q.ien) |=> irq_o);
    // R9
    irq_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(r_q.flag && r_q.ien) |=> !irq_o);
    // R3
    bad_src_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (src != SRC_BUS && src != SRC_PER && src != SRC_OSC) |-> !step);
endmodule

// File: tb/test_cmp_timer.sv
module test_cmp_timer;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 8;
    localparam int MASK       = (1 << CNT_W) - 1;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_t = 1'b0, per_t = 1'b0, osc_t = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  addr = 6'h24;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int    total = 0, bad = 0;
    string phase = "R1";
    bit    done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmp_timer #(.CNT_W(CNT_W)) i_cmp_timer (
        .clk_i(clk), .rst_ni(rst_n), .bus_tick_i(bus_t), .per_tick_i(per_t),
        .osc_tick_i(osc_t), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata), .irq_o(irq)
    );

    // behavioural reference
    int unsigned m_ctrl, m_div, m_cmp, m_cnt;
    int          m_flag, m_ien, m_irq, osc_n, main_n;

    function automatic int unsigned model_read(logic [5:0] a);
        case (a)
            6'h00: return m_ctrl;
            6'h04: return m_div;
            6'h08: return m_flag;
            6'h0C: return m_ien;
            6'h10: return m_cmp;
            6'h24: return m_cnt;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        int on, s_osc, s_sel, stp, hit, nxt_irq, src;
        if (!rst_n) begin
            m_ctrl = 0; m_div = 0; m_cmp = MASK; m_cnt = 0;
            m_flag = 0; m_ien = 0; m_irq = 0; osc_n = 0; main_n = 0;
        end else begin
            on      = m_ctrl & 1;
            nxt_irq = m_flag & m_ien;
            s_osc   = 0;
            if (((m_ctrl >> 10) & 1) == 0) begin
                osc_n = 0;
                s_osc = osc_t;
            end else if (!on) begin
                osc_n = 0;
            end else if (osc_t) begin
                if (osc_n >= int'((m_div >> 12) & 15)) begin s_osc = 1; osc_n = 0; end
                else osc_n++;
            end
            src   = (m_ctrl >> 6) & 7;
            s_sel = (src == 1) ? bus_t : (src == 2) ? per_t : (src == 5) ? s_osc : 0;
            stp   = 0;
            if (!on) main_n = 0;
            else if (s_sel) begin
                if (main_n >= int'(m_div & 12'hFFF)) begin stp = 1; main_n = 0; end
                else main_n++;
            end
            hit = 0;
            if (!on) m_cnt = 0;
            else if (stp) begin
                if ((((m_ctrl >> 9) & 1) == 0) && m_cnt == m_cmp) m_cnt = 0;
                else m_cnt = (m_cnt + 1) & MASK;
                hit = (m_cnt == m_cmp);
            end
            if (wr_en && addr == 6'h08 && wdata[0]) m_flag = 0;
            if (hit) m_flag = 1;
            if (wr_en) begin
                case (addr)
                    6'h00: m_ctrl = wdata;
                    6'h04: m_div  = wdata;
                    6'h0C: m_ien  = wdata[0];
                    6'h10: m_cmp  = wdata & MASK;
                    default: ;
                endcase
            end
            m_irq = nxt_irq;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(phase, rdata, model_read(addr));
            chk(phase, {31'd0, irq}, {31'd0, 1'(m_irq)});
        end
    end

    // strobe patterns
    always @(posedge clk) begin
        #1;
        bus_t = ($urandom % 2) == 0;
        per_t = ($urandom % 3) == 0;
        osc_t = ($urandom % 4) != 0;
    end

    task automatic wr(logic [5:0] a, logic [31:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0; addr = 6'h24; wdata = '0;
    endtask

    task automatic rd(logic [5:0] a, logic [31:0] exp, string tag);
        @(posedge clk); #1;
        addr = a;
        @(negedge clk);
        chk(tag, rdata, exp);
        @(posedge clk); #1;
        addr = 6'h24;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset values
        phase = "R1";
        rd(6'h00, 0, "R1"); rd(6'h04, 0, "R1"); rd(6'h08, 0, "R1");
        rd(6'h0C, 0, "R1"); rd(6'h10, MASK, "R1"); rd(6'h24, 0, "R1");
        chk("R1", {31'd0, irq}, 32'd0);
        // R11 undefined offset and counter write ignored
        phase = "R11";
        rd(6'h30, 0, "R11");
        wr(6'h24, 32'h55);
        rd(6'h24, 0, "R11");
        // R2 enabled-off: source set but not enabled
        phase = "R2";
        wr(6'h00, 32'h040); idle(20);
        rd(6'h24, 0, "R2");
        // R7 restart on bus strobe, compare 5, interrupt on
        phase = "R7";
        wr(6'h10, 5); wr(6'h0C, 1);
        wr(6'h00, 32'h041); idle(60);
        // R9 mask without clearing flag
        phase = "R9";
        wr(6'h0C, 0); idle(4);
        rd(6'h08, 1, "R9");
        chk("R9", {31'd0, irq}, 32'd0);
        wr(6'h0C, 1); idle(4);
        // R8 write 0 keeps, write 1 clears
        phase = "R8";
        wr(6'h00, 32'h000);
        wr(6'h08, 0); rd(6'h08, 1, "R8");
        wr(6'h08, 1); rd(6'h08, 0, "R8");
        // R4 main divider on peripheral strobe
        phase = "R4";
        wr(6'h04, 3); wr(6'h10, 9);
        wr(6'h00, 32'h081); idle(300);
        // R5 oscillator path with its divider (ratio 3), then undivided
        phase = "R5";
        wr(6'h00, 0);
        wr(6'h04, 32'h2001);
        wr(6'h00, 32'h541); idle(200);
        wr(6'h00, 32'h141); idle(100);
        // R3 unsupported source code 3
        phase = "R3";
        wr(6'h00, 0); wr(6'h04, 0);
        wr(6'h00, 32'h0C1); idle(40);
        rd(6'h24, 0, "R3");
        // R6 free-run through match and wrap
        phase = "R6";
        wr(6'h10, 10);
        wr(6'h00, 32'h241); idle(700);
        // R10 compare change mid-run in restart mode
        phase = "R10";
        wr(6'h00, 32'h041); idle(30);
        wr(6'h10, 3); idle(30);
        wr(6'h10, 0); idle(20);
        // R8 clear attempted while matches keep coming
        phase = "R8";
        repeat (10) begin wr(6'h08, 1); idle(1); end
        // R2 disable clears counter
        phase = "R2";
        wr(6'h00, 0);
        rd(6'h24, 0, "R2");
        idle(5);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule